// File: doc/BRIEF.md
# Raster Display Mode Timing Sequencer

This block paces a small tile-based display controller, one step per dot-clock cycle. It counts the dot position inside the current scanline and the scanline number inside the frame. From that position it reports which of four display phases is active: sprite search, active drawing, horizontal blank or vertical blank. It also gives one-dot strobes at the start of each line and at the start of vertical blank, and it produces two clock enables for the memory rate and the CPU rate.

The length of active drawing depends on how many sprites sit on the line. The sprite count comes in from the sprite search logic and is sampled at dot 0 of each line. Horizontal blank takes up whatever is left of the fixed line length, so every line lasts the same number of dots.

A second, purely combinational path decides whether a CPU access to video RAM or to sprite attribute RAM may go through in the current phase. A refused write is dropped. A refused read returns all ones instead of the memory data.

Top module: `raster_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer goes to line 0, dot 0. In that state `mode` reads sprite search (2), `line_stb` is 1 and `frame_stb` is 0.
- R2: Every line lasts exactly 456 dots. `dot` counts 0 to 455 and then wraps to 0, and `line` advances by one at that wrap.
- R3: On visible lines (0 to 143), dots 0 to 79 are in sprite search, which is `mode` = 2.
- R4: Active drawing (`mode` = 3) starts at dot 80 and lasts 168 + 10*min(n,10) dots. Here n is the `spr_count` value present during dot 0 of that line; changing `spr_count` later in the line has no effect on that line.
- R5: On visible lines, horizontal blank (`mode` = 0) covers every dot from the end of active drawing up to dot 455.
- R6: Lines 144 to 153 are entirely vertical blank (`mode` = 1). After line 153, `line` returns to 0, so a frame is 154 lines or 70224 dots.
- R7: `line_stb` is high exactly at dot 0 of every line. `frame_stb` is high only at dot 0 of line 144, which is once per frame.
- R8: `mem_ce` is high on even dots and `cpu_ce` is high on dots that are multiples of 4. This gives 114 CPU enables per line, aligned to dot 0.
- R9: A request with `cpu_sel` = 0 (video RAM) during active drawing is refused. `cpu_grant` is 0 and `cpu_rdata` is 0xFF.
- R10: A request with `cpu_sel` = 1 (sprite attribute RAM) during sprite search or active drawing is refused. `cpu_grant` is 0 and `cpu_rdata` is 0xFF.
- R11: In any phase where a region is not refused, `cpu_grant` equals `cpu_req` and `cpu_rdata` passes `mem_rdata` through. `cpu_grant` is 0 whenever `cpu_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, which is also the master clock |
| rst | input | 1 | Synchronous reset, active high |
| spr_count | input | 4 | Number of sprites on the line, sampled at dot 0 |
| mode | output | 2 | 0 horizontal blank, 1 vertical blank, 2 sprite search, 3 active drawing |
| line | output | 8 | Current line number, 0 to 153 |
| dot | output | 9 | Current dot within the line, 0 to 455 |
| line_stb | output | 1 | High at dot 0 of every line |
| frame_stb | output | 1 | High at dot 0 of line 144 |
| mem_ce | output | 1 | Memory-rate enable, every second dot |
| cpu_ce | output | 1 | CPU-rate enable, every fourth dot |
| cpu_req | input | 1 | CPU access request |
| cpu_sel | input | 1 | Region select: 0 video RAM, 1 sprite attribute RAM |
| cpu_we | input | 1 | Write request when 1, read when 0 |
| mem_rdata | input | 8 | Read data from the selected memory |
| cpu_grant | output | 1 | Access allowed this dot |
| cpu_rdata | output | 8 | Read data seen by the CPU, 0xFF when refused |

## Verification
The assertions assume only that `rst` is held for at least one edge before checking begins, and that the gating inputs are stable around the sampling point, since the access path has no state. `spr_count` may take any 4-bit value, including values above the clamp. The stimulus covers this by using counts of 0, 3, 10 and 15 and by changing the count in the middle of a line. Every input change happens on the falling edge, half a period away from the edge where the count is sampled.

// File: rtl/raster_seq.sv
module raster_seq #(
  parameter int LINE_DOTS    = 456,
  parameter int SEARCH_DOTS  = 80,
  parameter int DRAW_BASE    = 168,
  parameter int DOTS_PER_SPR = 10,
  parameter int MAX_SPR      = 10,
  parameter int VIS_LINES    = 144,
  parameter int TOTAL_LINES  = 154,
  parameter int SPR_W        = 4,
  parameter int DATA_W       = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SPR_W-1:0]               spr_count,
  output logic [1:0]                     mode,
  output logic [$clog2(TOTAL_LINES)-1:0] line,
  output logic [$clog2(LINE_DOTS)-1:0]   dot,
  output logic                           line_stb,
  output logic                           frame_stb,
  output logic                           mem_ce,
  output logic                           cpu_ce,
  input  logic                           cpu_req,
  input  logic                           cpu_sel,
  input  logic                           cpu_we,
  input  logic [DATA_W-1:0]              mem_rdata,
  output logic                           cpu_grant,
  output logic [DATA_W-1:0]              cpu_rdata
);
  localparam int DW = $clog2(LINE_DOTS);
  localparam int LW = $clog2(TOTAL_LINES);
  localparam logic [1:0] M_HBLANK = 2'd0;
  localparam logic [1:0] M_VBLANK = 2'd1;
  localparam logic [1:0] M_SEARCH = 2'd2;
  localparam logic [1:0] M_DRAW   = 2'd3;

  logic [SPR_W-1:0] spr_q, spr_lim;
  logic [1:0]       div;
  logic [DW-1:0]    draw_end;
  logic             last_dot, blocked;

  assign spr_lim  = (spr_count > SPR_W'(MAX_SPR)) ? SPR_W'(MAX_SPR) : spr_count;
  assign last_dot = (dot == DW'(LINE_DOTS - 1));
  assign draw_end = DW'(SEARCH_DOTS + DRAW_BASE) + DW'(DOTS_PER_SPR) * DW'(spr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot   <= '0;
      line  <= '0;
      spr_q <= '0;
      div   <= '0;
    end else begin
      div <= div + 2'd1;
      if (dot == '0) spr_q <= spr_lim;
      if (last_dot) begin
        dot  <= '0;
        line <= (line == LW'(TOTAL_LINES - 1)) ? '0 : line + LW'(1);
      end else begin
        dot <= dot + DW'(1);
      end
    end
  end

  always_comb begin
    if (line >= LW'(VIS_LINES))        mode = M_VBLANK;
    else if (dot < DW'(SEARCH_DOTS))   mode = M_SEARCH;
    else if (dot < draw_end)           mode = M_DRAW;
    else                               mode = M_HBLANK;
  end

  assign line_stb  = (dot == '0);
  assign frame_stb = line_stb && (line == LW'(VIS_LINES));
  assign mem_ce    = ~div[0];
  assign cpu_ce    = (div == 2'd0);

  assign blocked   = cpu_sel ? mode[1] : (mode == M_DRAW);
  assign cpu_grant = cpu_req & ~blocked;
  assign cpu_rdata = blocked ? '1 : mem_rdata;

  logic unused_we;
  assign unused_we = cpu_we;

  p_dot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    last_dot |=> (dot == '0 && line_stb));
  p_line_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (last_dot && line != LW'(TOTAL_LINES - 1)) |=> (line == $past(line) + LW'(1)));
  p_frame_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (last_dot && line == LW'(TOTAL_LINES - 1)) |=> (line == '0 && mode == M_SEARCH));
  p_draw_after_search_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SEARCH && dot == DW'(SEARCH_DOTS - 1)) |=> (mode == M_DRAW));
  p_hblank_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_HBLANK && !last_dot) |=> (mode == M_HBLANK));
  p_vblank_entry_r7: assert property (@(posedge clk) disable iff (rst)
    (last_dot && line == LW'(VIS_LINES - 1)) |=> (frame_stb && mode == M_VBLANK));
  p_cpu_ce_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |=> (!cpu_ce && !mem_ce));
  p_vram_block_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DRAW && cpu_req && !cpu_sel) |-> (!cpu_grant && cpu_rdata == '1));
  p_oam_block_r10: assert property (@(posedge clk) disable iff (rst)
    (mode != M_HBLANK && mode != M_VBLANK && cpu_req && cpu_sel) |-> !cpu_grant);
  p_no_req_r11: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |-> !cpu_grant);
endmodule

// File: tb/raster_seq_bench.sv
module raster_seq_bench;
  localparam int LD = 456;
  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] spr_count = '0;
  logic [1:0] mode;
  logic [7:0] line;
  logic [8:0] dot;
  logic line_stb, frame_stb, mem_ce, cpu_ce;
  logic cpu_req = 1'b0, cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [7:0] mem_rdata = 8'h5A;
  logic cpu_grant;
  logic [7:0] cpu_rdata;
  int n_chk = 0, n_fail = 0, ed = 0, el = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_seq u_raster_seq (
    .clk(clk), .rst(rst), .spr_count(spr_count), .mode(mode), .line(line), .dot(dot),
    .line_stb(line_stb), .frame_stb(frame_stb), .mem_ce(mem_ce), .cpu_ce(cpu_ce),
    .cpu_req(cpu_req), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .mem_rdata(mem_rdata),
    .cpu_grant(cpu_grant), .cpu_rdata(cpu_rdata));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (ed == LD - 1) begin ed = 0; el = (el == 153) ? 0 : el + 1; end
    else ed++;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; ed = 0; el = 0;
    chk(dot == 0 && line == 0, "R1 position", {line, dot}, 0);
    chk(mode == 2'd2, "R1 mode", mode, 2);
    chk(line_stb && !frame_stb, "R1 strobes", {line_stb, frame_stb}, 2);
  endtask

  task automatic t_line(input int n, input bit midchange);
    int ns = 0, nd = 0, nh = 0, nchg = 0, badce = 0, badstb = 0, exp_d;
    logic [1:0] prev;
    exp_d = 168 + 10 * ((n > 10) ? 10 : n);
    spr_count = 4'(n);
    chk(mode == 2'd2 && dot == 0, "R3 line start", mode, 2);
    prev = mode;
    for (int i = 0; i < LD; i++) begin
      if (mode == 2'd2) ns++;
      else if (mode == 2'd3) nd++;
      else if (mode == 2'd0) nh++;
      if (mode != prev) nchg++;
      prev = mode;
      if (mem_ce != (ed % 2 == 0) || cpu_ce != (ed % 4 == 0)) badce++;
      if (line_stb != (ed == 0) || frame_stb) badstb++;
      tick();
      if (i == 0 && midchange) spr_count = 4'd0;
    end
    chk(ns == 80, "R3 search dots", ns, 80);
    chk(nd == exp_d, "R4 draw dots", nd, exp_d);
    chk(nh == LD - 80 - exp_d && nchg == 2, "R5 hblank dots", nh, LD - 80 - exp_d);
    chk(badce == 0, "R8 enables", badce, 0);
    chk(badstb == 0, "R7 line strobe", badstb, 0);
    chk(dot == 0 && line == 8'(el), "R2 line advance", line, el);
  endtask

  task automatic acc(input bit vblk, input bit oblk, input string tag);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 2; w++) begin
        bit b;
        b = s ? oblk : vblk;
        cpu_req = 1'b1; cpu_sel = s[0]; cpu_we = w[0];
        #1;
        chk(cpu_grant == !b, tag, cpu_grant, !b);
        chk(cpu_rdata == (b ? 8'hFF : 8'h5A), tag, cpu_rdata, b ? 255 : 90);
      end
    end
    cpu_req = 1'b0; #1;
    chk(!cpu_grant, "R11 no request", cpu_grant, 0);
  endtask

  task automatic t_access();
    spr_count = 4'd0;
    while (ed != 10) tick();
    acc(1'b0, 1'b1, "R10 search gating");
    while (ed != 100) tick();
    acc(1'b1, 1'b1, "R9 draw gating");
    while (ed != 300) tick();
    acc(1'b0, 1'b0, "R11 hblank gating");
    while (ed != 0) tick();
  endtask

  task automatic t_frame();
    int dots = 0, lstb = 0, fstb = 0, badv = 0, badl = 0;
    spr_count = 4'd2;
    while (!(el == 144 && ed == 0)) tick();
    chk(frame_stb && line == 144, "R7 frame strobe", frame_stb, 1);
    acc(1'b0, 1'b0, "R11 vblank gating");
    do begin
      dots++;
      if (line_stb) lstb++;
      if (frame_stb) fstb++;
      if (el >= 144 && mode != 2'd1) badv++;
      if (line != 8'(el) || dot != 9'(ed)) badl++;
      tick();
    end while (!frame_stb && dots < 80000);
    chk(dots == 70224, "R6 frame dots", dots, 70224);
    chk(lstb == 154 && fstb == 1, "R7 strobe counts", lstb, 154);
    chk(badv == 0, "R6 vblank lines", badv, 0);
    chk(badl == 0, "R2 counters", badl, 0);
  endtask

  initial begin
    t_reset();
    t_line(0, 1'b0);
    t_line(3, 1'b0);
    t_line(10, 1'b0);
    t_line(15, 1'b1);
    t_access();
    t_frame();
    t_reset();
    t_line(7, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule